// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block takes the first and last address of a memory span and produces the partial-store mask for one aligned 8-byte block of that span. The mask has one bit per element, with elements of 8, 16 or 32 bits. The start address chooses the leftmost element that is enabled. When the end address falls in the same aligned block, the mask is also limited on the right at the last element. A software loop uses it on the first and last blocks of a copy or fill, where a store must not write bytes outside the span.

The mask can follow either big-endian or little-endian element order. A narrow mode cuts both addresses to 32 bits before any mask choice or block comparison. In the same operation the block can also report the integer condition flags that the subtraction first-minus-second gives, at both 32-bit and 64-bit width, on the full untruncated addresses. A control input turns this flag report off.

Top module: `edge_mask_unit`

## Requirements
- R1: In big-endian 8-bit mode (`elem_size`=0, `little_end`=0), with k the low 3 bits of an address, the left mask is 0xFF shifted right by k and the right mask has the top k+1 of its 8 bits set.
- R2: In little-endian 8-bit mode, the left mask is 0xFF shifted left by k and cut to 8 bits, and the right mask has the low k+1 bits set.
- R3: With `elem_size`=1 (16-bit), address bits [2:1] give j. Big-endian: left = 0xF>>j, right = top j+1 of 4 bits. Little-endian: left = (0xF<<j) cut to 4 bits, right = low j+1 bits.
- R4: With `elem_size`=2 (32-bit), address bit 2 gives j. Big-endian: left is 3 or 1 and right is 2 or 3. Little-endian: left is 3 or 2 and right is 1 or 3.
- R5: The left mask comes from `addr_a` and the right mask from `addr_b`. The output is left AND right when the two addresses are equal with their low 3 bits cleared, and the left mask alone otherwise.
- R6: With `narrow_addr`=1, both addresses are cut to their low 32 bits before the mask is chosen and before the block comparison.
- R7: `xcc` = {N,Z,V,C} (bit 3 down to bit 0) of the 64-bit subtraction `addr_a`-`addr_b` on the full addresses. C is the unsigned borrow and V is the signed overflow.
- R8: `icc` = {N,Z,V,C} of the same subtraction done on bits [31:0] only. `narrow_addr` does not change it.
- R9: When `no_flags`=1 at start, `flags_valid` is 0 and `icc` and `xcc` are 0. Otherwise `flags_valid` is 1.
- R10: All outputs are registered. `out_valid` is high for exactly one cycle, in the cycle after `start`. Without `start`, `mask`, `icc`, `xcc` and `flags_valid` keep their values. Reset clears every output to 0.
- R11: Mask bits above the element count (4 for 16-bit, 2 for 32-bit) are 0. The `elem_size` value 3 behaves as 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation on the current inputs |
| addr_a | input | 64 | First (start) address |
| addr_b | input | 64 | Second (end) address |
| elem_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 8-bit |
| little_end | input | 1 | 1 selects little-endian element order |
| no_flags | input | 1 | 1 turns off the condition flag report |
| narrow_addr | input | 1 | 1 cuts the addresses to 32 bits for the mask |
| out_valid | output | 1 | Result pulse, one cycle after start |
| mask | output | 8 | Element mask |
| flags_valid | output | 1 | Flags were produced for the last operation |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C} |

## Verification
The assertions assume that `elem_size`, `no_flags`, `narrow_addr` and both addresses are held steady in the cycle `start` is sampled, because each property looks back one cycle to the operands behind a result. The bench drives every input once at a falling edge, holds it through the next rising edge, and lets `start` go only at the falling edge after that. The random addresses put the end address inside the start block about half the time, so both the AND path and the left-only path are used heavily. Some draws make the upper halves differ while the low halves stay close, which checks that narrow mode keeps the truncated mask apart from the full-width flags.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
    localparam int ADDR_W    = 64;
    localparam int NARROW_W  = 32;
    localparam int BLK_BYTES = 8;
    localparam int MASK_W    = BLK_BYTES;
    localparam int OFF_W     = $clog2(BLK_BYTES);

    typedef enum logic [1:0] {
        ESZ_B8   = 2'd0,
        ESZ_B16  = 2'd1,
        ESZ_B32  = 2'd2,
        ESZ_RSVD = 2'd3
    } esize_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccflags_t;

    typedef struct packed {
        logic              valid;
        logic [MASK_W-1:0] mask;
        logic              fvalid;
        ccflags_t          fl32;
        ccflags_t          fl64;
    } out_reg_t;
endpackage

// File: rtl/edge_addr_prep.sv
module edge_addr_prep #(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32,
    parameter int OFF_W    = 3
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              narrow_addr,
    output logic [OFF_W-1:0]  off_a,
    output logic [OFF_W-1:0]  off_b,
    output logic              same_blk
);
    localparam int HI_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff_a;
    logic [ADDR_W-1:0] eff_b;

    always_comb begin
        eff_a = addr_a;
        eff_b = addr_b;
        if (narrow_addr) begin
            eff_a = {{(ADDR_W-NARROW_W){1'b0}}, addr_a[NARROW_W-1:0]};
            eff_b = {{(ADDR_W-NARROW_W){1'b0}}, addr_b[NARROW_W-1:0]};
        end
        off_a    = eff_a[OFF_W-1:0];
        off_b    = eff_b[OFF_W-1:0];
        same_blk = (eff_a[ADDR_W-1 -: HI_W] == eff_b[ADDR_W-1 -: HI_W]);
    end
endmodule

// File: rtl/edge_lane_mask.sv
module edge_lane_mask
    import edge_mask_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int OFF_W  = 3
) (
    input  esize_e            esize,
    input  logic              little_end,
    input  logic [OFF_W-1:0]  off_a,
    input  logic [OFF_W-1:0]  off_b,
    input  logic              same_blk,
    output logic [MASK_W-1:0] mask
);
    logic [MASK_W-1:0] lft;
    logic [MASK_W-1:0] rgt;
    int                shamt;
    int                lanes;
    int                ja;
    int                jb;

    always_comb begin
        case (esize)
            ESZ_B16: shamt = 1;
            ESZ_B32: shamt = 2;
            default: shamt = 0;
        endcase
        lanes = MASK_W >> shamt;
        ja    = int'(off_a) >> shamt;
        jb    = int'(off_b) >> shamt;
        lft   = '0;
        rgt   = '0;
        for (int b = 0; b < MASK_W; b++) begin
            int pos;
            pos = little_end ? b : (lanes - 1 - b);
            if (b < lanes) begin
                lft[b] = (pos >= ja);
                rgt[b] = (pos <= jb);
            end
        end
        mask = same_blk ? (lft & rgt) : lft;
    end
endmodule

// File: rtl/edge_sub_flags.sv
module edge_sub_flags
    import edge_mask_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output ccflags_t     flags
);
    logic [W-1:0] diff;

    always_comb begin
        diff    = op_a - op_b;
        flags.n = diff[W-1];
        flags.z = (diff == '0);
        flags.v = (op_a[W-1] ^ op_b[W-1]) & (diff[W-1] ^ op_a[W-1]);
        flags.c = (op_a < op_b);
    end
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
    import edge_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [1:0]        elem_size,
    input  logic              little_end,
    input  logic              no_flags,
    input  logic              narrow_addr,
    output logic              out_valid,
    output logic [MASK_W-1:0] mask,
    output logic              flags_valid,
    output logic [3:0]        icc,
    output logic [3:0]        xcc
);
    logic [OFF_W-1:0]  off_a;
    logic [OFF_W-1:0]  off_b;
    logic              same_blk;
    logic [MASK_W-1:0] mask_comb;
    ccflags_t          fl_word;
    ccflags_t          fl_full;
    out_reg_t          res_d;
    out_reg_t          res_q;

    edge_addr_prep #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .OFF_W    (OFF_W)
    ) u_prep (
        .addr_a      (addr_a),
        .addr_b      (addr_b),
        .narrow_addr (narrow_addr),
        .off_a       (off_a),
        .off_b       (off_b),
        .same_blk    (same_blk)
    );

    edge_lane_mask #(
        .MASK_W (MASK_W),
        .OFF_W  (OFF_W)
    ) u_lane (
        .esize      (esize_e'(elem_size)),
        .little_end (little_end),
        .off_a      (off_a),
        .off_b      (off_b),
        .same_blk   (same_blk),
        .mask       (mask_comb)
    );

    edge_sub_flags #(.W(NARROW_W)) u_fl_word (
        .op_a  (addr_a[NARROW_W-1:0]),
        .op_b  (addr_b[NARROW_W-1:0]),
        .flags (fl_word)
    );

    edge_sub_flags #(.W(ADDR_W)) u_fl_full (
        .op_a  (addr_a),
        .op_b  (addr_b),
        .flags (fl_full)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = start;
        if (start) begin
            res_d.mask   = mask_comb;
            res_d.fvalid = !no_flags;
            res_d.fl32   = no_flags ? '0 : fl_word;
            res_d.fl64   = no_flags ? '0 : fl_full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign mask        = res_q.mask;
    assign flags_valid = res_q.fvalid;
    assign icc         = res_q.fl32;
    assign xcc         = res_q.fl64;
endmodule

// File: rtl/edge_mask_chk.sv
module edge_mask_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [63:0] addr_a,
    input logic [63:0] addr_b,
    input logic [1:0]  elem_size,
    input logic        no_flags,
    input logic        narrow_addr,
    input logic        out_valid,
    input logic [7:0]  mask,
    input logic        flags_valid,
    input logic [3:0]  icc,
    input logic [3:0]  xcc
);
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(mask) && $stable(icc) && $stable(xcc) && $stable(flags_valid)));

    p_width16_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(elem_size) == 2'd1) |-> (mask[7:4] == 4'h0));

    p_width32_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(elem_size) == 2'd2) |-> (mask[7:2] == 6'h0));

    p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(no_flags)) |-> (!flags_valid && icc == 4'h0 && xcc == 4'h0));

    p_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(no_flags)) |-> flags_valid);

    p_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(no_flags) && $past(addr_a) == $past(addr_b))
            |-> (xcc == 4'b0100 && icc == 4'b0100));

    p_left_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(narrow_addr) && $past(addr_a[63:3]) != $past(addr_b[63:3]))
            |-> (mask != 8'h00));
endmodule

bind edge_mask_unit edge_mask_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .elem_size   (elem_size),
    .no_flags    (no_flags),
    .narrow_addr (narrow_addr),
    .out_valid   (out_valid),
    .mask        (mask),
    .flags_valid (flags_valid),
    .icc         (icc),
    .xcc         (xcc)
);

// File: tb/tb_edge_mask_unit.sv
`timescale 1ns/1ps
module tb_edge_mask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] addr_a = '0;
    logic [63:0] addr_b = '0;
    logic [1:0]  elem_size = '0;
    logic        little_end = 1'b0;
    logic        no_flags = 1'b0;
    logic        narrow_addr = 1'b0;
    logic        out_valid;
    logic [7:0]  mask;
    logic        flags_valid;
    logic [3:0]  icc;
    logic [3:0]  xcc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    edge_mask_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_a(addr_a), .addr_b(addr_b),
        .elem_size(elem_size), .little_end(little_end), .no_flags(no_flags),
        .narrow_addr(narrow_addr), .out_valid(out_valid), .mask(mask),
        .flags_valid(flags_valid), .icc(icc), .xcc(xcc)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mask(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                                            logic le, logic nar);
        logic [63:0] aa, bb;
        int sh, ones, ja, jb, l, r;
        aa = nar ? {32'h0, a[31:0]} : a;
        bb = nar ? {32'h0, b[31:0]} : b;
        sh = (sz == 2'd2) ? 2 : (sz == 2'd1) ? 1 : 0;
        ones = (1 << (8 >> sh)) - 1;
        ja = int'(aa[2:0]) >> sh;
        jb = int'(bb[2:0]) >> sh;
        if (le) begin
            l = (ones << ja) & ones;
            r = ones & ~(ones << (jb + 1));
        end else begin
            l = ones >> ja;
            r = ones & ~(ones >> (jb + 1));
        end
        if (aa[63:3] == bb[63:3]) l = l & r;
        return l[7:0];
    endfunction

    function automatic logic [3:0] ref_fl64(logic [63:0] a, logic [63:0] b);
        logic [64:0] d;
        logic signed [64:0] s;
        d = {1'b0, a} - {1'b0, b};
        s = $signed({a[63], a}) - $signed({b[63], b});
        return {d[63], d[63:0] == 64'h0, s[64] ^ s[63], d[64]};
    endfunction

    function automatic logic [3:0] ref_fl32(logic [63:0] a, logic [63:0] b);
        logic [32:0] d;
        logic signed [32:0] s;
        d = {1'b0, a[31:0]} - {1'b0, b[31:0]};
        s = $signed({a[31], a[31:0]}) - $signed({b[31], b[31:0]});
        return {d[31], d[31:0] == 32'h0, s[32] ^ s[31], d[32]};
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                          input logic le, input logic nf, input logic nar, input string tag);
        logic [7:0] em;
        logic [3:0] e32, e64;
        @(negedge clk);
        addr_a = a; addr_b = b; elem_size = sz; little_end = le;
        no_flags = nf; narrow_addr = nar; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        em  = ref_mask(a, b, sz, le, nar);
        e32 = nf ? 4'h0 : ref_fl32(a, b);
        e64 = nf ? 4'h0 : ref_fl64(a, b);
        chk(out_valid === 1'b1, "R10 out_valid", 64'(out_valid), 64'h1);
        chk(mask === em, tag, 64'(mask), 64'(em));
        if (sz == 2'd1) chk(mask[7:4] === 4'h0, "R11 upper16", 64'(mask), 64'(em));
        if (sz == 2'd2) chk(mask[7:2] === 6'h0, "R11 upper32", 64'(mask), 64'(em));
        chk(flags_valid === !nf, "R9 flags_valid", 64'(flags_valid), 64'(!nf));
        chk(icc === e32, nf ? "R9 icc" : "R8 icc", 64'(icc), 64'(e32));
        chk(xcc === e64, nf ? "R9 xcc" : "R7 xcc", 64'(xcc), 64'(e64));
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] held_m;
        logic [3:0] held_x;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && mask === 8'h0 && flags_valid === 1'b0 && icc === 4'h0 && xcc === 4'h0,
            "R10 reset", {out_valid, mask, flags_valid, icc, xcc}, 64'h0);
        rst_n = 1'b1;

        run_op(64'h1003, 64'h2005, 2'd0, 1'b0, 1'b0, 1'b0, "R1 be8 diff");
        run_op(64'h0007, 64'h0007, 2'd0, 1'b0, 1'b0, 1'b0, "R1 be8 k7");
        run_op(64'h0000, 64'h0000, 2'd0, 1'b0, 1'b0, 1'b0, "R1 be8 k0");
        run_op(64'h0002, 64'h0010, 2'd0, 1'b1, 1'b0, 1'b0, "R2 le8 diff");
        run_op(64'h0001, 64'h0006, 2'd0, 1'b1, 1'b0, 1'b0, "R2 le8 same");
        run_op(64'h0002, 64'h0006, 2'd1, 1'b0, 1'b0, 1'b0, "R3 be16");
        run_op(64'h0002, 64'h0006, 2'd1, 1'b1, 1'b0, 1'b0, "R3 le16");
        run_op(64'h0004, 64'h0004, 2'd2, 1'b0, 1'b0, 1'b0, "R4 be32");
        run_op(64'h0004, 64'h0013, 2'd2, 1'b1, 1'b0, 1'b0, "R4 le32");
        run_op(64'h0005, 64'h0002, 2'd0, 1'b0, 1'b0, 1'b0, "R5 and empty");
        run_op(64'hAAAA_0000_0000_0010, 64'h5555_0000_0000_0013, 2'd0, 1'b0, 1'b0, 1'b1, "R6 narrow same");
        run_op(64'hAAAA_0000_0000_0010, 64'h5555_0000_0000_0013, 2'd0, 1'b0, 1'b0, 1'b0, "R6 wide diff");
        run_op(64'h8000_0000_0000_0000, 64'h1, 2'd0, 1'b0, 1'b0, 1'b0, "R7 overflow");
        run_op(64'h0000_0001_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R8 low borrow");
        run_op(64'h10, 64'h20, 2'd1, 1'b0, 1'b1, 1'b0, "R9 suppressed");
        run_op(64'h0003, 64'h0006, 2'd3, 1'b1, 1'b0, 1'b0, "R11 size3");

        held_m = mask;
        held_x = xcc;
        addr_a = 64'h1234; addr_b = 64'h1; elem_size = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 no pulse", 64'(out_valid), 64'h0);
        chk(mask === held_m && xcc === held_x, "R10 hold", {mask, xcc}, {held_m, held_x});

        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: b = {$urandom, $urandom};
                1: b = {a[63:3], 3'($urandom)};
                2: b = {$urandom, a[31:3], 3'($urandom)};
                default: b = a + 64'($urandom_range(0, 24));
            endcase
            run_op(a, b, 2'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                   1'($urandom), "R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule